// File: doc/BRIEF.md
# Transmit Descriptor Completion Write-Back Controller

This block sits behind a transmit DMA engine and receives every descriptor that the engine has finished. It decides when the done status of those descriptors is written back to host memory and when the head pointer seen by software moves forward. Completed descriptors enter a 64-entry completion cache. They stay there until a release is triggered. Once released, they drain in ring order, one write-back request per cycle over a valid/ready handshake.

Two events trigger a release. A descriptor with report-status set forces an early release. Without such a descriptor, the cache holds entries until half of it is filled with unreleased completions. A descriptor with zero buffer length still takes part in ordering and in head movement, but it never gets a status write. Alongside the batching, the block checks each descriptor's format and command consistency and tracks packet boundaries, so that it can flag a packet long enough to deadlock the batching scheme.

Top module: `txwb_ctrl`

## Requirements
- R1: A descriptor is accepted when `desc_valid_i` and `desc_ready_o` are both high at a clock edge. The cycle after acceptance, `fmt_err_o` pulses when the type field is not 4'b0011, when command bit 5 (extended format) is 0, or when reserved command bit 2 or bit 4 is 1.
- R2: The command bits are: bit 0 end of packet, bit 1 insert FCS, bit 3 report status, bit 6 VLAN insert, bit 7 segmentation. For the first descriptor of a packet, `cmd_err_o` pulses the cycle after acceptance when bit 7, bit 6 or `desc_csum_i` is set while bit 1 is clear. Later descriptors of the same packet never raise it.
- R3: Without report status, no write-back request and no head update appear until 32 unreleased completions are held. The 32nd acceptance then releases all of them.
- R4: Accepting a descriptor with command bit 3 set releases every held completion, that descriptor included.
- R5: A descriptor with `desc_len_i` equal to 0 never produces a write-back request. It is still released in order and still moves the head.
- R6: Write-back requests leave in acceptance order. `wb_idx_o` carries the descriptor's ring index and `wb_status_o` equals 4'b0001 (bit 0 is the done flag). A request stays valid with a stable index until `wb_ready_i` is high, and at most one request completes per cycle.
- R7: When the last released entry leaves the cache, `head_valid_o` pulses for one cycle. `head_o` becomes that entry's index plus one, wrapped to 0 at `ring_size_i`.
- R8: Bit 0 ends a packet. The descriptor that makes a packet's length reach `ring_size_i` - 30 descriptors raises `span_err_o` the cycle after acceptance.
- R9: After reset `head_o` is 0, `head_valid_o` and `wb_valid_o` are low, and `desc_ready_o` is high.
- R10: When 64 entries are cached, `desc_ready_o` is low until an entry leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_size_i | input | IDX_W+1 | Number of ring entries (32 or more) |
| desc_valid_i | input | 1 | Completed descriptor offered |
| desc_ready_o | output | 1 | Cache can take a descriptor |
| desc_cmd_i | input | 8 | Command byte |
| desc_type_i | input | 4 | Descriptor type field |
| desc_csum_i | input | 1 | Checksum offload requested |
| desc_len_i | input | LEN_W | Buffer length |
| desc_idx_i | input | IDX_W | Ring index of the descriptor |
| wb_valid_o | output | 1 | Status write-back request |
| wb_ready_i | input | 1 | Write-back accepted |
| wb_idx_o | output | IDX_W | Ring index to write |
| wb_status_o | output | 4 | Status nibble, bit 0 done |
| head_valid_o | output | 1 | Head pointer update pulse |
| head_o | output | IDX_W | Published head pointer |
| fmt_err_o | output | 1 | Format error pulse |
| cmd_err_o | output | 1 | Command consistency error pulse |
| span_err_o | output | 1 | Packet span error pulse |

## Verification
The assertions assume that `ring_size_i` is at least 32 and changes only while the cache is empty and no packet is open. They also assume that every `desc_idx_i` is below the ring size. The stimulus meets these conditions in three ways. Ring indices are generated sequentially modulo the current ring size. The ring size is changed only after a drain and after a packet has been closed with end of packet. Long open packets appear only in a directed span case, which is sized against a reduced ring.

// File: rtl/txwb_pkg.sv
package txwb_pkg;
  localparam int CMD_EOP  = 0;
  localparam int CMD_IFCS = 1;
  localparam int CMD_RSV0 = 2;
  localparam int CMD_RS   = 3;
  localparam int CMD_RSV1 = 4;
  localparam int CMD_DEXT = 5;
  localparam int CMD_VLE  = 6;
  localparam int CMD_TSE  = 7;
  localparam logic [3:0] TYPE_ADV  = 4'b0011;
  localparam logic [3:0] STATUS_DD = 4'b0001;
endpackage

// File: rtl/txwb_fifo.sv
module txwb_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 data_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 data_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));

  // R10: occupancy never passes the cache depth
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/txwb_release.sv
module txwb_release #(
  parameter int CW   = 7,
  parameter int HALF = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          force_i,
  input  logic          pop_i,
  output logic [CW-1:0] rel_cnt_o,
  output logic          last_o
);
  logic [CW-1:0] unc_q, rel_q, unc_inc;
  logic          commit;

  always_comb begin
    unc_inc = unc_q + CW'(push_i);
    commit  = push_i && (force_i || (unc_inc >= CW'(HALF)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unc_q <= '0;
      rel_q <= '0;
    end else begin
      unc_q <= commit ? '0 : unc_inc;
      rel_q <= rel_q - CW'(pop_i) + (commit ? unc_inc : '0);
    end
  end

  assign rel_cnt_o = rel_q;
  // batch ends only when nothing new joined it this cycle
  assign last_o    = pop_i && (rel_q == CW'(1)) && !commit;

  // R3: unreleased completions stay below the batch threshold
  a_r3_unc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_q < CW'(HALF));
endmodule

// File: rtl/txwb_check.sv
module txwb_check
  import txwb_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [7:0]       cmd_i,
  input  logic [3:0]       type_i,
  input  logic             csum_i,
  input  logic [IDX_W:0]   ring_size_i,
  output logic             fmt_err_o,
  output logic             cmd_err_o,
  output logic             span_err_o
);
  localparam logic [IDX_W:0] CNT_MAX = '1;

  logic           in_pkt_q;
  logic [IDX_W:0] pkt_cnt_q, cnt_nxt, span_hit;
  logic           first, fmt_bad, cmd_bad;

  always_comb begin
    first    = !in_pkt_q;
    cnt_nxt  = first ? (IDX_W+1)'(1)
             : (pkt_cnt_q == CNT_MAX) ? pkt_cnt_q : pkt_cnt_q + (IDX_W+1)'(1);
    span_hit = ring_size_i - (IDX_W+1)'(30);
    fmt_bad  = (type_i != TYPE_ADV) || !cmd_i[CMD_DEXT] || cmd_i[CMD_RSV0] || cmd_i[CMD_RSV1];
    cmd_bad  = first && (cmd_i[CMD_TSE] || cmd_i[CMD_VLE] || csum_i) && !cmd_i[CMD_IFCS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q   <= 1'b0;
      pkt_cnt_q  <= '0;
      fmt_err_o  <= 1'b0;
      cmd_err_o  <= 1'b0;
      span_err_o <= 1'b0;
    end else begin
      fmt_err_o  <= acc_i && fmt_bad;
      cmd_err_o  <= acc_i && cmd_bad;
      span_err_o <= acc_i && (cnt_nxt == span_hit);
      if (acc_i) begin
        in_pkt_q  <= !cmd_i[CMD_EOP];
        pkt_cnt_q <= cmd_i[CMD_EOP] ? '0 : cnt_nxt;
      end
    end
  end

  // R1, R2, R8: error pulses only follow an acceptance
  a_r1_err_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_err_o || cmd_err_o || span_err_o) |-> $past(acc_i));
  // R8: the packet count restarts after end of packet
  a_r8_pkt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && cmd_i[CMD_EOP]) |=> !in_pkt_q);
endmodule

// File: rtl/txwb_ctrl.sv
module txwb_ctrl
  import txwb_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 16,
  parameter int DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W:0]    ring_size_i,
  input  logic              desc_valid_i,
  output logic              desc_ready_o,
  input  logic [7:0]        desc_cmd_i,
  input  logic [3:0]        desc_type_i,
  input  logic              desc_csum_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic [IDX_W-1:0]  desc_idx_i,
  output logic              wb_valid_o,
  input  logic              wb_ready_i,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [3:0]        wb_status_o,
  output logic              head_valid_o,
  output logic [IDX_W-1:0]  head_o,
  output logic              fmt_err_o,
  output logic              cmd_err_o,
  output logic              span_err_o
);
  localparam int HALF = DEPTH / 2;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int EW   = IDX_W + 1;

  logic           acc, pop, full, last, hd_zero;
  logic [EW-1:0]  fifo_in, fifo_out;
  logic [CW-1:0]  fifo_cnt, rel_cnt;
  logic [IDX_W-1:0] hd_idx;
  logic [IDX_W:0] nxt_wide;
  logic [IDX_W-1:0] head_q;
  logic           head_vld_q;

  assign acc     = desc_valid_i && desc_ready_o;
  assign fifo_in = {(desc_len_i == '0), desc_idx_i};
  assign hd_zero = fifo_out[EW-1];
  assign hd_idx  = fifo_out[IDX_W-1:0];
  // zero-length entries retire without a status write
  assign pop     = (rel_cnt != '0) && (hd_zero || wb_ready_i);

  txwb_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (acc),
    .data_i (fifo_in),
    .pop_i  (pop),
    .data_o (fifo_out),
    .count_o(fifo_cnt),
    .full_o (full)
  );

  txwb_release #(.CW(CW), .HALF(HALF)) u_rel (
    .clk_i, .rst_ni,
    .push_i   (acc),
    .force_i  (desc_cmd_i[CMD_RS]),
    .pop_i    (pop),
    .rel_cnt_o(rel_cnt),
    .last_o   (last)
  );

  txwb_check #(.IDX_W(IDX_W)) u_chk (
    .clk_i, .rst_ni,
    .acc_i      (acc),
    .cmd_i      (desc_cmd_i),
    .type_i     (desc_type_i),
    .csum_i     (desc_csum_i),
    .ring_size_i(ring_size_i),
    .fmt_err_o  (fmt_err_o),
    .cmd_err_o  (cmd_err_o),
    .span_err_o (span_err_o)
  );

  assign nxt_wide = {1'b0, hd_idx} + (IDX_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q     <= '0;
      head_vld_q <= 1'b0;
    end else begin
      head_vld_q <= last;
      if (last) head_q <= (nxt_wide >= ring_size_i) ? '0 : nxt_wide[IDX_W-1:0];
    end
  end

  assign desc_ready_o = !full;
  assign wb_valid_o   = (rel_cnt != '0) && !hd_zero;
  assign wb_idx_o     = hd_idx;
  assign wb_status_o  = STATUS_DD;
  assign head_valid_o = head_vld_q;
  assign head_o       = head_q;

  // R6: a stalled request holds its index
  a_r6_wb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_idx_o)));
  // R10: released entries are always present in the cache
  a_r10_rel_in_cache: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_cnt <= fifo_cnt);
  // R7: published head lies inside the ring
  a_r7_head_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_o |-> ({1'b0, head_o} < ring_size_i));
endmodule

// File: tb/txwb_ctrl_tb_top.sv
`timescale 1ns/100ps
module txwb_ctrl_tb_top;
  localparam int IDX_W = 8;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W:0]   ring_size = 9'd64;
  logic             desc_valid = 1'b0;
  logic             desc_ready;
  logic [7:0]       desc_cmd = '0;
  logic [3:0]       desc_type = 4'b0011;
  logic             desc_csum = 1'b0;
  logic [LEN_W-1:0] desc_len = '0;
  logic [IDX_W-1:0] desc_idx = '0;
  logic             wb_valid, wb_ready = 1'b0;
  logic [IDX_W-1:0] wb_idx, head;
  logic [3:0]       wb_status;
  logic             head_valid, fmt_err, cmd_err, span_err;

  int checks = 0, errors = 0;
  int rdy_mode = 2;              // 0 stall, 1 random, 2 always ready
  int next_idx = 0;
  int exp_q[$];
  int allowed = 0, written = 0, head_events = 0;
  int unc_all = 0, unc_nz = 0;
  int exp_head = 0;
  bit m_in_pkt = 0;
  int m_cnt = 0;
  logic [2:0] exp_err = '0;
  bit running = 0;

  always #2.5 clk = ~clk;

  txwb_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W), .DEPTH(64)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ring_size_i(ring_size),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
    .desc_cmd_i(desc_cmd), .desc_type_i(desc_type), .desc_csum_i(desc_csum),
    .desc_len_i(desc_len), .desc_idx_i(desc_idx),
    .wb_valid_o(wb_valid), .wb_ready_i(wb_ready), .wb_idx_o(wb_idx),
    .wb_status_o(wb_status), .head_valid_o(head_valid), .head_o(head),
    .fmt_err_o(fmt_err), .cmd_err_o(cmd_err), .span_err_o(span_err)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic int wrap_next(input int idx, input int ring);
    return (idx + 1 >= ring) ? 0 : idx + 1;
  endfunction

  function automatic logic [2:0] pred_err(input logic [7:0] c, input logic [3:0] t,
                                          input bit cs, input bit first, input int cnt,
                                          input int ring);
    logic [2:0] e;
    e[2] = (t != 4'b0011) || !c[5] || c[2] || c[4];
    e[1] = first && (c[7] || c[6] || cs) && !c[1];
    e[0] = (cnt == ring - 30);
    return e;
  endfunction

  // monitor and reference model, sampled on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        logic [2:0] got, nxt_err;
        got = {fmt_err, cmd_err, span_err};
        nxt_err = '0;
        if (exp_err != 3'b000 || got != 3'b000) begin
          chk(got[2] == exp_err[2], "R1", $sformatf("fmt_err %0b exp %0b", got[2], exp_err[2]));
          chk(got[1] == exp_err[1], "R2", $sformatf("cmd_err %0b exp %0b", got[1], exp_err[1]));
          chk(got[0] == exp_err[0], "R8", $sformatf("span_err %0b exp %0b", got[0], exp_err[0]));
        end
        if (wb_valid && wb_ready) begin
          chk(written < allowed, "R3", $sformatf("write-back %0d before release, allowed %0d", written, allowed));
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5", $sformatf("unexpected write-back idx %0d exp none", wb_idx));
          end else begin
            chk(int'(wb_idx) == exp_q[0], "R6", $sformatf("wb idx %0d exp %0d", wb_idx, exp_q[0]));
            void'(exp_q.pop_front());
          end
          chk(wb_status == 4'b0001, "R6", $sformatf("status %0h exp 1", wb_status));
          written++;
        end
        if (head_valid) head_events++;
        if (desc_valid && desc_ready) begin
          bit first;
          int cnt;
          first = !m_in_pkt;
          cnt = first ? 1 : m_cnt + 1;
          nxt_err = pred_err(desc_cmd, desc_type, desc_csum, first, cnt, int'(ring_size));
          m_in_pkt = !desc_cmd[0];
          m_cnt = desc_cmd[0] ? 0 : cnt;
          unc_all++;
          if (desc_len != 0) begin
            exp_q.push_back(int'(desc_idx));
            unc_nz++;
          end
          if (desc_cmd[3] || unc_all >= 32) begin
            allowed += unc_nz;
            unc_all = 0;
            unc_nz = 0;
            exp_head = wrap_next(int'(desc_idx), int'(ring_size));
          end
        end
        exp_err = nxt_err;
      end
    end
  end

  // write-back ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      case (rdy_mode)
        0: wb_ready = 1'b0;
        1: wb_ready = ($urandom % 4) != 0;
        default: wb_ready = 1'b1;
      endcase
    end
  end

  task automatic send(input logic [7:0] c, input logic [3:0] t, input bit cs, input int len);
    desc_valid = 1'b1;
    desc_cmd   = c;
    desc_type  = t;
    desc_csum  = cs;
    desc_len   = LEN_W'(len);
    desc_idx   = IDX_W'(next_idx);
    next_idx   = wrap_next(next_idx, int'(ring_size));
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    @(posedge clk);
    #1;
    desc_valid = 1'b0;
  endtask

  task automatic drain_and_check_head(input string tag);
    int n = 0;
    int h0;
    h0 = head_events;
    while ((exp_q.size() != 0 || written != allowed) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6", $sformatf("%s: %0d write-backs missing, exp 0", tag, exp_q.size()));
    chk(head_events > h0, "R7", $sformatf("%s: head updates %0d exp more than %0d", tag, head_events, h0));
    chk(int'(head) == exp_head, "R7", $sformatf("%s: head %0d exp %0d", tag, head, exp_head));
    @(posedge clk);
    #1;
  endtask

  localparam logic [7:0] C_OK     = 8'b0010_0011; // DEXT|IFCS|EOP
  localparam logic [7:0] C_MID    = 8'b0010_0010; // DEXT|IFCS
  localparam logic [7:0] C_OK_RS  = 8'b0010_1011;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(head == 0, "R9", $sformatf("head %0d exp 0", head));
    chk(!wb_valid && !head_valid, "R9", $sformatf("wb_valid %0b head_valid %0b exp 0", wb_valid, head_valid));
    chk(desc_ready == 1'b1, "R9", $sformatf("desc_ready %0b exp 1", desc_ready));
    rst_n = 1'b1;
    running = 1;
    @(posedge clk);
    #1;

    // R5: lone zero-length descriptor with report status
    send(C_OK_RS, 4'b0011, 0, 0);
    drain_and_check_head("zero-len");
    chk(written == 0, "R5", $sformatf("writes %0d exp 0", written));

    // R4: report status releases everything held
    send(C_OK, 4'b0011, 0, 64);
    send(C_OK, 4'b0011, 0, 0);
    send(C_OK_RS, 4'b0011, 0, 8);
    drain_and_check_head("rs-force");
    chk(written == 2, "R4", $sformatf("writes %0d exp 2", written));

    // R3: 31 without report status stay held, 32nd releases
    for (int i = 0; i < 31; i++) send(C_OK, 4'b0011, 0, 100);
    repeat (40) @(negedge clk);
    chk(written == 2, "R3", $sformatf("writes %0d exp 2 while held", written));
    chk(!wb_valid, "R3", $sformatf("wb_valid %0b exp 0 while held", wb_valid));
    @(posedge clk); #1;
    send(C_OK, 4'b0011, 0, 100);
    drain_and_check_head("batch");
    chk(written == 34, "R3", $sformatf("writes %0d exp 34", written));

    // R1, R2: format and command checks
    send(8'b0000_0011, 4'b0011, 0, 10);    // DEXT clear
    send(C_OK, 4'b0001, 0, 10);            // wrong type
    send(8'b0011_0011, 4'b0011, 0, 10);    // reserved bit 4
    send(8'b1010_0000, 4'b0011, 0, 10);    // TSE without IFCS, first
    send(8'b0100_0001, 4'b0011, 0, 10);    // mid packet: VLE without IFCS, no cmd error
    send(8'b0010_0000, 4'b0011, 1, 10);    // csum without IFCS, first
    send(8'b0010_1001, 4'b0011, 0, 10);    // mid packet, close with RS
    drain_and_check_head("err");

    // R10: stall write-back until the cache fills
    rdy_mode = 0;
    for (int i = 0; i < 64; i++) send(C_OK, 4'b0011, 0, 5);
    @(negedge clk);
    chk(desc_ready == 1'b0, "R10", $sformatf("desc_ready %0b exp 0 when full", desc_ready));
    chk(wb_valid == 1'b1, "R6", $sformatf("wb_valid %0b exp 1 while stalled", wb_valid));
    @(posedge clk); #1;
    rdy_mode = 1;
    drain_and_check_head("full");

    // R8: packet span limit on a 40-entry ring
    ring_size = 9'd40;
    next_idx = 0;
    for (int i = 0; i < 11; i++) send(C_MID, 4'b0011, 0, 20);
    send(C_OK_RS, 4'b0011, 0, 20);
    drain_and_check_head("span");

    // random phase with wrap on the 40-entry ring, then 64
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < 300; i++) begin
        logic [7:0] c;
        logic [3:0] t;
        c = 8'($urandom);
        if (($urandom % 10) != 0) c[5] = 1'b1;
        if (($urandom % 10) != 0) begin c[2] = 1'b0; c[4] = 1'b0; end
        c[3] = ($urandom % 8) == 0;
        c[0] = ($urandom % 3) == 0;
        t = (($urandom % 10) == 0) ? 4'($urandom) : 4'b0011;
        send(c, t, 1'($urandom), (($urandom % 8) == 0) ? 0 : int'($urandom % 1500) + 1);
      end
      send(C_OK_RS, 4'b0011, 0, 60);
      drain_and_check_head("random");
      ring_size = 9'd64;
      next_idx = 0;
    end

    running = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule